// File: doc/BRIEF.md
# Bus Ownership Request Sequencer

This block sequences how one bus master obtains the shared bus from a central arbiter. The handshake uses three wires: request, grant and grant acknowledge. A local cycle engine raises a level request when it has a burst of bus cycles to run. The sequencer drives bus request toward the arbiter and waits for the grant. It then waits until the bus is quiet, meaning the address strobe is negated and no other master holds grant acknowledge. It claims the bus by driving grant acknowledge low and raises an `owned` flag, which lets the engine start its cycles. One clock later it withdraws the request, and that makes the arbiter drop its grant. Grant acknowledge stays driven until the engine signals that its burst is done.

The same sequencer serves an external master and an on-chip requester such as a DMA engine or refresh logic. The bus-side inputs (grant, address strobe, grant acknowledge) are asynchronous to the local clock, so each passes through a synchronizer of `SYNC_STAGES` flops, two by default. Address strobe and grant acknowledge are active-low at the pins. Grant and request are active-high.

There are six states:
- IDLE: nothing driven.
- REQUEST: request driven, waiting for grant.
- WAIT_IDLE: grant seen, waiting for strobe and acknowledge to clear.
- OWN_BR: acknowledge and request both driven.
- OWN: acknowledge only.
- RELEASE: acknowledge dropped, waiting to see it negated on the bus.

The transitions are:
- IDLE→REQUEST: on a request while the bus acknowledge is negated.
- REQUEST→WAIT_IDLE: on grant.
- WAIT_IDLE→OWN_BR: once strobe and acknowledge are both negated.
- OWN_BR→OWN: unconditionally after one clock.
- OWN_BR or OWN→RELEASE: on done.
- RELEASE→IDLE: once the bus acknowledge reads negated.

Top module: `bus_mastership_seq`

## Requirements
- R1: While reset is asserted, `bus_req_o`=0, `bgack_n_o`=1 and `owned_o`=0.
- R2: In IDLE, with the synchronized bus acknowledge negated, a high `xfer_req_i` drives `bus_req_o` high on the next clock edge, and it stays high while no grant is seen.
- R3: `bgack_n_o` is never driven low unless `bus_req_o` was high in the previous cycle, and it stays high until a grant has been observed.
- R4: After a grant, `bgack_n_o` stays high until both `as_n_i` and `bgack_n_i` have read high through the synchronizer. It falls on the clock after the later of the two is seen high.
- R5: `owned_o` is high exactly when `bgack_n_o` is low.
- R6: `bus_req_o` falls on the clock edge after the one on which `bgack_n_o` falls.
- R7: While owned, `bgack_n_o` stays low until `xfer_done_i` is sampled high. On the next edge `bgack_n_o` returns high and `owned_o` falls.
- R8: A request is not accepted (`bus_req_o` stays low) while the synchronized bus acknowledge is asserted, including right after this block's own release. It is accepted on the edge after the acknowledge is seen negated.
- R9: Each bus-side input reaches the state machine after `SYNC_STAGES` flops. With the default of 2, a grant driven between edges N and N+1, on an otherwise quiet bus, gives `bgack_n_o` low after edge N+4.
- R10: `xfer_done_i` has no effect outside OWN_BR and OWN. In REQUEST it leaves `bus_req_o` high and `owned_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | Local engine wants the bus (level) |
| xfer_done_i | input | 1 | Local engine finished its burst (pulse) |
| bus_grant_i | input | 1 | Grant from the arbiter, active high, asynchronous |
| as_n_i | input | 1 | Address strobe on the bus, active low, asynchronous |
| bgack_n_i | input | 1 | Grant acknowledge as seen on the bus (wired, includes own drive), active low |
| bus_req_o | output | 1 | Request to the arbiter, active high |
| bgack_n_o | output | 1 | This block's grant acknowledge drive, active low |
| owned_o | output | 1 | Bus held; the local engine may run cycles |

## Verification
Local inputs (`xfer_req_i`, `xfer_done_i`) take effect on the first edge after they change. Bus-side inputs take effect on edge `SYNC_STAGES`+1, because the state register follows the synchronizer. A grant on a quiet bus therefore shows on `bgack_n_o` at edge 4 and drops `bus_req_o` at edge 5. The driver task queues each expected output triple, tagged with the absolute cycle at which it is due, using these latencies. The monitor samples a quarter period after each rising edge and compares only the items due in that cycle. It checks the cycle just before each boundary as well as the boundary itself, so a change that comes early or late by one clock is caught.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REQUEST   = 3'd1,
        ST_WAIT_IDLE = 3'd2,
        ST_OWN_BR    = 3'd3,
        ST_OWN       = 3'd4,
        ST_RELEASE   = 3'd5
    } bms_state_e;

    typedef struct packed {
        logic req;    // bus request toward arbiter
        logic claim;  // drive grant acknowledge (active high internally)
        logic owned;  // local engine may run
    } bms_drive_t;

    localparam int unsigned BUS_IN_W = 3;
    localparam int unsigned IDX_BG    = 0;
    localparam int unsigned IDX_AS    = 1;
    localparam int unsigned IDX_BGACK = 2;

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[LAST];

endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
    import bms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       done_i,
    input  logic       bg_s_i,
    input  logic       as_s_i,
    input  logic       bgack_s_i,
    output bms_state_e state_o
);
    bms_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_i && !bgack_s_i)  state_d = ST_REQUEST;
            ST_REQUEST:   if (bg_s_i)               state_d = ST_WAIT_IDLE;
            ST_WAIT_IDLE: if (!as_s_i && !bgack_s_i) state_d = ST_OWN_BR;
            ST_OWN_BR:    state_d = done_i ? ST_RELEASE : ST_OWN;
            ST_OWN:       if (done_i)               state_d = ST_RELEASE;
            ST_RELEASE:   if (!bgack_s_i)           state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

    // R8: a busy acknowledge on the bus keeps the sequencer parked in IDLE
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bgack_s_i) |=> (state_q == ST_IDLE));

    // R4: no claim while strobe or acknowledge is still seen active
    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_IDLE && (as_s_i || bgack_s_i)) |=> (state_q == ST_WAIT_IDLE));

    // R10: done outside ownership does not move the machine out of REQUEST
    p_done_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQUEST && !bg_s_i) |=> (state_q == ST_REQUEST));

endmodule

// File: rtl/bms_drive.sv
module bms_drive
    import bms_pkg::*;
(
    input  bms_state_e state_i,
    output bms_drive_t drv_o
);
    always_comb begin
        drv_o = '0;
        unique case (state_i)
            ST_IDLE:      drv_o = '{req: 1'b0, claim: 1'b0, owned: 1'b0};
            ST_REQUEST:   drv_o = '{req: 1'b1, claim: 1'b0, owned: 1'b0};
            ST_WAIT_IDLE: drv_o = '{req: 1'b1, claim: 1'b0, owned: 1'b0};
            ST_OWN_BR:    drv_o = '{req: 1'b1, claim: 1'b1, owned: 1'b1};
            ST_OWN:       drv_o = '{req: 1'b0, claim: 1'b1, owned: 1'b1};
            ST_RELEASE:   drv_o = '{req: 1'b0, claim: 1'b0, owned: 1'b0};
            default:      drv_o = '0;
        endcase
    end
endmodule

// File: rtl/bus_mastership_seq.sv
module bus_mastership_seq
    import bms_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req_i,
    input  logic xfer_done_i,
    input  logic bus_grant_i,
    input  logic as_n_i,
    input  logic bgack_n_i,
    output logic bus_req_o,
    output logic bgack_n_o,
    output logic owned_o
);
    logic [BUS_IN_W-1:0] bus_raw, bus_s;
    bms_state_e          state;
    bms_drive_t          drv;

    // pins converted to active-high before synchronizing
    assign bus_raw[IDX_BG]    = bus_grant_i;
    assign bus_raw[IDX_AS]    = ~as_n_i;
    assign bus_raw[IDX_BGACK] = ~bgack_n_i;

    bms_sync #(
        .WIDTH   (BUS_IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_raw),
        .q_o   (bus_s)
    );

    bms_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (xfer_req_i),
        .done_i    (xfer_done_i),
        .bg_s_i    (bus_s[IDX_BG]),
        .as_s_i    (bus_s[IDX_AS]),
        .bgack_s_i (bus_s[IDX_BGACK]),
        .state_o   (state)
    );

    bms_drive u_drive (
        .state_i (state),
        .drv_o   (drv)
    );

    assign bus_req_o = drv.req;
    assign bgack_n_o = ~drv.claim;
    assign owned_o   = drv.owned;

    // R1: quiet outputs in reset
    always_comb begin
        if (!rst_n) p_reset_quiet_r1: assert (!bus_req_o && bgack_n_o && !owned_o);
    end

    // R3: acknowledge only follows a request
    p_claim_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bgack_n_o) |-> $past(bus_req_o));

    // R5: owned flag matches acknowledge drive
    p_owned_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        owned_o == !bgack_n_o);

    // R6: request withdrawn one clock after claim
    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bgack_n_o) |=> !bus_req_o);

    // R7: ownership held until done, released right after
    p_hold_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_o && !xfer_done_i) |=> owned_o);
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owned_o && xfer_done_i) |=> (bgack_n_o && !owned_o));

endmodule

// File: tb/tb_bus_mastership_seq.sv
module tb_bus_mastership_seq;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic xfer_req, xfer_done, bg, as_n, ext_bgack_n;
    logic bus_req, bgack_n, owned;
    logic bus_bgack_n;

    always #(PERIOD/2) clk = ~clk;

    // wired bus acknowledge: ours and another master's
    assign bus_bgack_n = bgack_n & ext_bgack_n;

    bus_mastership_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_req_i  (xfer_req),
        .xfer_done_i (xfer_done),
        .bus_grant_i (bg),
        .as_n_i      (as_n),
        .bgack_n_i   (bus_bgack_n),
        .bus_req_o   (bus_req),
        .bgack_n_o   (bgack_n),
        .owned_o     (owned)
    );

    typedef struct {
        int unsigned cyc;
        logic        br;
        logic        bgn;
        logic        own;
        string       tag;
    } exp_t;

    exp_t q[$];
    int unsigned cyc = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int unsigned d, logic br, logic bgn, logic own, string tag);
        exp_t e;
        e.cyc = cyc + d; e.br = br; e.bgn = bgn; e.own = own; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor: compare items due in this cycle
    always @(posedge clk) begin
        #(PERIOD/4);
        while (q.size() != 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc < cyc) begin
                errors++;
                $display("FAIL %s: missed sample cycle %0d (now %0d)", e.tag, e.cyc, cyc);
            end else if (bus_req !== e.br || bgack_n !== e.bgn || owned !== e.own) begin
                errors++;
                $display("FAIL %s @%0d: br/bgack_n/owned actual=%b%b%b expected=%b%b%b",
                         e.tag, cyc, bus_req, bgack_n, owned, e.br, e.bgn, e.own);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; xfer_req = 0; xfer_done = 0; bg = 0; as_n = 1; ext_bgack_n = 1;
        step(2);
        expect_at(1, 0, 1, 0, "R1");
        step(2);
        rst_n = 1'b1;
        step(2);
        drain();

        // basic acquisition on a quiet bus
        xfer_req = 1;
        expect_at(1, 1, 1, 0, "R2");
        expect_at(3, 1, 1, 0, "R2");
        step(3);
        bg = 1;
        expect_at(2, 1, 1, 0, "R3");
        expect_at(3, 1, 1, 0, "R9");
        expect_at(4, 1, 0, 1, "R9 R5");
        expect_at(5, 0, 0, 1, "R6");
        step(5);
        bg = 0;
        step(3);
        expect_at(1, 0, 0, 1, "R7");
        step(2);
        xfer_done = 1;                 // req kept high: re-request after release
        expect_at(1, 0, 1, 0, "R7");
        expect_at(4, 0, 1, 0, "R8");
        expect_at(5, 1, 1, 0, "R8");
        step(1);
        xfer_done = 0;
        drain();

        // bus busy with strobe and another owner's acknowledge
        as_n = 0; ext_bgack_n = 0;
        step(1);
        bg = 1;
        expect_at(4, 1, 1, 0, "R4");
        expect_at(6, 1, 1, 0, "R4");
        step(6);
        as_n = 1;
        expect_at(4, 1, 1, 0, "R4");
        step(4);
        ext_bgack_n = 1;
        expect_at(2, 1, 1, 0, "R4");
        expect_at(3, 1, 0, 1, "R4");
        expect_at(4, 0, 0, 1, "R6");
        step(4);
        bg = 0; xfer_req = 0;
        drain();
        xfer_done = 1;
        expect_at(1, 0, 1, 0, "R7");
        step(1);
        xfer_done = 0;
        step(6);
        expect_at(1, 0, 1, 0, "R8");
        drain();

        // done while only requesting is ignored
        xfer_req = 1;
        expect_at(1, 1, 1, 0, "R2");
        step(1);
        xfer_done = 1;
        step(1);
        xfer_done = 0;
        expect_at(1, 1, 1, 0, "R10");
        expect_at(4, 1, 1, 0, "R10");
        step(4);
        bg = 1;
        expect_at(4, 1, 0, 1, "R9");
        expect_at(5, 0, 0, 1, "R6");
        step(5);
        bg = 0; xfer_req = 0; xfer_done = 1;
        expect_at(1, 0, 1, 0, "R7");
        step(1);
        xfer_done = 0;
        step(5);
        drain();

        // request refused while another master holds acknowledge
        ext_bgack_n = 0;
        step(3);
        xfer_req = 1;
        expect_at(1, 0, 1, 0, "R8");
        expect_at(3, 0, 1, 0, "R8");
        step(3);
        ext_bgack_n = 1;
        expect_at(2, 0, 1, 0, "R8");
        expect_at(3, 1, 1, 0, "R8");
        step(3);
        xfer_req = 0;
        bg = 1;
        expect_at(4, 1, 0, 1, "R5");
        step(5);
        bg = 0; xfer_done = 1;
        expect_at(1, 0, 1, 0, "R7");
        step(1);
        xfer_done = 0;
        step(6);
        drain();

        finish_run();
    end

endmodule